// File: doc/BRIEF.md
# Memory bus cycle sequencer with refresh slot

This block is the processor-side engine that turns one memory request into a timed series of clock periods (T-states) on a 16-bit address bus and an 8-bit data bus. A request names one of three operations: instruction fetch, data read or data write. It also carries an address and, for writes, a byte to store. The sequencer drives the active-low memory-request, read, write, fetch-marker and refresh strobes. It controls the direction of the shared data lines through a separate output-enable. It stretches the cycle while the memory holds its wait line low. When the cycle finishes it reports the byte it read.

Every instruction fetch carries two extra T-states. In these the sequencer places a 7-bit refresh row number on the low address lines and asserts the refresh strobe while pulsing memory-request. The row number then advances, so dynamic memory behind the bus is refreshed in step with instruction fetches.

Requests enter through a valid/ready port. A request is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when the bus is idle or in the last T-state of a cycle, so back-to-back requests lose no clock. The requester must hold the request fields stable while `cmd_valid` is high and not yet accepted. The completion strobe `rsp_valid` has no ready: it is a one-cycle pulse, and `rsp_rdata` holds its value until the next fetch or read captures new data.

Top module: `zbus_sequencer`

## Requirements
- R1: After reset, all five strobes are high, `d_oe` is low, `cmd_ready` is high, `rsp_valid` is low, and the refresh row is zero.
- R2: `cmd_ready` is high in idle and in the last T-state of a cycle, and low in every other T-state. A request is accepted on an edge where `cmd_valid` and `cmd_ready` are both high, and T1 begins in the next cycle. The `cmd_op` codes are: 0 fetch, 1 read, 2 write, 3 read.
- R3: A fetch with no wait states lasts four T-states. In T1 and T2 the request address is on the bus, `m1_n`, `mreq_n` and `rd_n` are low, and `wr_n` and `rfsh_n` are high.
- R4: A read with no wait states lasts three T-states. It holds the address with `mreq_n` and `rd_n` low through T1–T3, and afterwards the bus returns to idle with all strobes high.
- R5: `wait_n` is sampled on the falling clock edge within T2 and within each wait state. Each low sample inserts one wait state, during which the strobes and address of T2 are held. A high sample leads to T3.
- R6: Data on `din` is captured on the rising edge that ends the last of T2 and the wait states. `rsp_valid` is high for exactly the final T-state, with the captured byte on `rsp_rdata`. A write leaves `rsp_rdata` unchanged.
- R7: In T3 and T4 of a fetch, `addr` carries zeros in bits 15..7 and the refresh row in bits 6..0. `rfsh_n` is low in both T-states, `mreq_n` is low in T3 only, and `m1_n`, `rd_n` and `wr_n` are high.
- R8: The refresh row increases by one after each fetch and wraps from 127 to 0.
- R9: A write lasts three T-states with no wait states. `mreq_n` is low from T1 to T3, and `wr_n` is low in T2 and in each wait state but high in T1 and T3. `d_oe` is high from T1 to T3 with the write byte on `dout`, and `rd_n` stays high.
- R10: `d_oe` is low whenever the bus is idle and throughout fetch and read cycles, and it is never high while `rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; T-states advance on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Sequencer can take a request this cycle |
| cmd_op | input | 2 | Operation: 0 fetch, 1 read, 2 write, 3 read |
| cmd_addr | input | 16 | Request address |
| cmd_wdata | input | 8 | Byte to store on a write |
| rsp_valid | output | 1 | One-cycle completion strobe in the final T-state |
| rsp_rdata | output | 8 | Last byte captured by a fetch or read |
| addr | output | 16 | Address bus |
| dout | output | 8 | Data driven onto the data lines |
| din | input | 8 | Data seen on the data lines |
| d_oe | output | 1 | Data line output enable (high = drive) |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m1_n | output | 1 | Fetch-cycle marker, active low |
| rfsh_n | output | 1 | Refresh strobe, active low |
| wait_n | input | 1 | Memory not ready, active low |

## Verification
Counting from the edge that accepts a request, T1 outputs appear one cycle later, T2 two cycles later, and each wait state requested adds one cycle before T3. A fetch has one more cycle, T4, and idle follows the final T-state by one cycle. The bench drives inputs 1 ns after a rising edge, changes `wait_n` before the falling edge that samples it, and compares every output 4 ns after the edge, so each T-state is checked in the cycle it occupies. To confirm that the data byte is taken on the edge entering T3 and no later, `din` is corrupted right after that edge. The refresh row is predicted as a count of completed fetches modulo 128.

// File: rtl/zbus_pkg.sv
package zbus_pkg;
  typedef enum logic [1:0] {
    OP_FETCH = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ2 = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_TW   = 3'd3,
    S_T3   = 3'd4,
    S_T4   = 3'd5
  } tstate_e;

  function automatic kind_e op_to_kind(input logic [1:0] op);
    case (op)
      2'd0:    return K_FETCH;
      2'd2:    return K_WRITE;
      default: return K_READ;
    endcase
  endfunction
endpackage

// File: rtl/zbus_tstate_fsm.sv
module zbus_tstate_fsm
  import zbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  kind_e   start_kind,
  input  logic    wait_hold,
  output tstate_e state,
  output kind_e   kind,
  output logic    last,
  output logic    capture,
  output logic    row_adv
);
  tstate_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:      nxt = start ? S_T1 : S_IDLE;
      S_T1:        nxt = S_T2;
      S_T2, S_TW:  nxt = wait_hold ? S_TW : S_T3;
      S_T3:        nxt = (kind == K_FETCH) ? S_T4 : (start ? S_T1 : S_IDLE);
      S_T4:        nxt = start ? S_T1 : S_IDLE;
      default:     nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      kind  <= K_READ;
    end else begin
      state <= nxt;
      if (start) kind <= start_kind;
    end
  end

  assign last    = (state == S_T4) || ((state == S_T3) && (kind != K_FETCH));
  assign capture = ((state == S_T2) || (state == S_TW)) && !wait_hold && (kind != K_WRITE);
  assign row_adv = (state == S_T4);

  // R5: a low wait sample keeps the cycle in a wait state
  a_r5_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_T2) || (state == S_TW)) && wait_hold |=> state == S_TW);
  // R5: a high sample leaves the wait state for T3
  a_r5_wait_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TW) && !wait_hold |=> state == S_T3);
  // R3: a fetch always continues into T4
  a_r3_fetch_has_t4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_T3) && (kind == K_FETCH) |=> state == S_T4);
endmodule

// File: rtl/zbus_datapath.sv
module zbus_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  input  logic              wait_n,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              wait_hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        addr_q  <= cmd_addr;
        wdata_q <= cmd_wdata;
      end
      if (capture) rdata_q <= din;
    end
  end

  // wait line taken on the falling edge, mid T-state
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) wait_hold <= 1'b0;
    else        wait_hold <= ~wait_n;
  end

  // R6: captured byte only changes on a capture edge
  a_r6_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rdata_q));
endmodule

// File: rtl/zbus_refresh_row.sv
module zbus_refresh_row #(
  parameter int ROW_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   row <= '0;
    else if (adv) row <= row + 1'b1;
  end

  // R8: row is untouched outside the refresh advance
  a_r8_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(row));
endmodule

// File: rtl/zbus_sequencer.sv
module zbus_sequencer
  import zbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  input  logic [DATA_W-1:0] din,
  output logic              d_oe,
  output logic              mreq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m1_n,
  output logic              rfsh_n,
  input  logic              wait_n
);
  localparam int PAD_W = ADDR_W - ROW_W;

  tstate_e           state;
  kind_e             kind;
  logic              last, capture, row_adv, wait_hold, start;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [ROW_W-1:0]  row;
  logic              in_addr_ph, in_strobe_ph, in_refresh;

  assign cmd_ready = (state == S_IDLE) || last;
  assign start     = cmd_valid && cmd_ready;

  zbus_tstate_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_kind(op_to_kind(cmd_op)),
    .wait_hold(wait_hold), .state(state), .kind(kind), .last(last),
    .capture(capture), .row_adv(row_adv)
  );

  zbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .capture(capture), .din(din), .wait_n(wait_n),
    .addr_q(addr_q), .wdata_q(wdata_q), .rdata_q(rdata_q), .wait_hold(wait_hold)
  );

  zbus_refresh_row #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .adv(row_adv), .row(row)
  );

  assign in_addr_ph   = (state == S_T1) || (state == S_T2) || (state == S_TW);
  assign in_strobe_ph = (state == S_T2) || (state == S_TW);
  assign in_refresh   = (kind == K_FETCH) && ((state == S_T3) || (state == S_T4));

  assign addr   = in_refresh ? {{PAD_W{1'b0}}, row} : addr_q;
  assign mreq_n = !(in_addr_ph || (state == S_T3));
  assign rd_n   = !((kind != K_WRITE) && in_addr_ph || (kind == K_READ) && (state == S_T3));
  assign wr_n   = !((kind == K_WRITE) && in_strobe_ph);
  assign m1_n   = !((kind == K_FETCH) && in_addr_ph);
  assign rfsh_n = !in_refresh;
  assign d_oe   = (kind == K_WRITE) && (in_addr_ph || (state == S_T3));
  assign dout   = wdata_q;

  assign rsp_valid = last;
  assign rsp_rdata = rdata_q;

  // R10: never drive the data lines while reading
  a_r10_oe_not_read: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> rd_n);
  // R4: a read strobe is always accompanied by memory request
  a_r4_rd_with_mreq: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !mreq_n);
  // R9: read and write strobes are never low together
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  // R7: refresh excludes fetch marker and read strobe
  a_r7_rfsh_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> (m1_n && rd_n));
  // R2: an accepted request opens T1 on the next cycle
  a_r2_accept_t1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !mreq_n && !cmd_ready);
endmodule

// File: tb/zbus_sequencer_tb.sv
`timescale 1ns/1ps
module zbus_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [15:0] addr;
  logic [7:0]  dout;
  logic [7:0]  din = '0;
  logic        d_oe, mreq_n, rd_n, wr_n, m1_n, rfsh_n;
  logic        wait_n = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int exp_row = 0;
  logic [7:0] last_rd = 8'h00;

  always #2.5 clk = ~clk;

  zbus_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .addr(addr), .dout(dout),
    .din(din), .d_oe(d_oe), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .m1_n(m1_n), .rfsh_n(rfsh_n), .wait_n(wait_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bus_now();
    return {10'b0, addr, mreq_n, rd_n, wr_n, m1_n, rfsh_n, d_oe};
  endfunction

  function automatic logic [31:0] bus_exp(input logic [15:0] a, input logic mq, rd, wr, m1, rf, oe);
    return {10'b0, a, mq, rd, wr, m1, rf, oe};
  endfunction

  // one complete cycle: op, address, write byte, read byte, wait states
  task automatic run(input logic [1:0] op, input logic [15:0] a, input logic [7:0] wd,
                     input logic [7:0] rv, input int nw);
    bit fe, wrt;
    logic [15:0] ra;
    fe  = (op == 2'd0);
    wrt = (op == 2'd2);
    ra  = 16'(exp_row);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd; din = rv; wait_n = 1'b1;
    #3 chk("R2 ready in idle", {31'b0, cmd_ready}, 32'd1);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    #3;
    chk(fe ? "R3 T1" : (wrt ? "R9 T1" : "R4 T1"), bus_now(),
        bus_exp(a, 1'b0, wrt, 1'b1, !fe, 1'b1, wrt));
    chk("R2 busy in T1", {31'b0, cmd_ready}, 32'd0);
    if (wrt) chk("R9 dout", {24'b0, dout}, {24'b0, wd});
    for (int k = 0; k <= nw; k++) begin
      @(posedge clk); #1;
      wait_n = (k < nw) ? 1'b0 : 1'b1;
      #3;
      chk(k == 0 ? (fe ? "R3 T2" : (wrt ? "R9 T2" : "R4 T2")) : "R5 wait state", bus_now(),
          bus_exp(a, 1'b0, wrt, !wrt, !fe, 1'b1, wrt));
      chk("R6 no early done", {31'b0, rsp_valid}, 32'd0);
    end
    @(posedge clk); #1;
    wait_n = 1'b1;
    din = ~rv;
    #3;
    if (fe) begin
      chk("R7 R8 refresh T3", bus_now(), bus_exp(ra, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0));
      chk("R6 fetch byte", {24'b0, rsp_rdata}, {24'b0, rv});
      @(posedge clk); #4;
      chk("R7 refresh T4", bus_now(), bus_exp(ra, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0));
      exp_row = (exp_row + 1) % 128;
      last_rd = rv;
    end else if (wrt) begin
      chk("R9 T3", bus_now(), bus_exp(a, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1));
      chk("R6 write keeps rdata", {24'b0, rsp_rdata}, {24'b0, last_rd});
    end else begin
      chk("R4 T3", bus_now(), bus_exp(a, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0));
      chk("R6 read byte", {24'b0, rsp_rdata}, {24'b0, rv});
      last_rd = rv;
    end
    chk("R6 done strobe", {31'b0, rsp_valid}, 32'd1);
    chk("R2 ready in last", {31'b0, cmd_ready}, 32'd1);
    @(posedge clk); #4;
    chk("R10 R4 idle after", {26'b0, mreq_n, rd_n, wr_n, m1_n, rfsh_n, d_oe},
        {26'b0, 6'b111110});
    chk("R6 strobe ends", {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #11;
    chk("R1 reset strobes", {26'b0, mreq_n, rd_n, wr_n, m1_n, rfsh_n, d_oe}, {26'b0, 6'b111110});
    chk("R1 reset handshake", {30'b0, cmd_ready, rsp_valid}, {30'b0, 2'b10});
    rst_n = 1'b1;
    // first fetch exposes the reset row value of zero (R1)
    run(2'd0, 16'h1234, 8'h00, 8'h3C, 0);
    for (int op = 0; op < 4; op++)
      for (int nw = 0; nw < 4; nw++)
        for (int s = 0; s < 3; s++)
          run(op[1:0], 16'(16'h0101 * (s * 85 + op * 7 + nw) ^ 16'h8000 * s),
              8'(op * 37 + nw * 11 + s), 8'(8'hA5 ^ (op * 16 + nw * 4 + s)), nw);
    // run the refresh row past its wrap point (R8)
    for (int i = 0; i < 130; i++)
      run(2'd0, 16'(i * 513), 8'h00, 8'(i), i % 2);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule